// File: doc/BRIEF.md
# Interrupt Source Router with Event Queues

This block routes interrupt triggers from a small set of sources into circular event queues. Every source owns a two-bit coalescing state and a routing entry. The routing entry holds a mask, a target CPU, a priority and an event-data word. When a trigger is accepted in the ready state on an unmasked source, the block emits one queue write. The write names the queue, its slot index and the entry word, and a one-cycle notify pulse carries the target CPU and priority. The queue storage itself sits outside the block: the write strobe lands in external memory. The block only keeps each queue's running index and generation toggle bit.

Triggers arrive on a valid/ready stream that carries a source number. A plain register port shares the event path with that stream. Software uses it to program routing entries, to force coalescing states, to size and restart queues, and to issue end-of-interrupt (EOI) operations. Back-pressure on the trigger stream has one cause only. `trig_ready` is low in every cycle in which `cfg_en` is high. A trigger held valid across that cycle must keep `trig_src` stable, and it is taken on the next cycle with `cfg_en` low. The queue-write and notify outputs are strobes with no back-pressure. At most one queue write happens per cycle.

Top module: `irq_event_router`

## Requirements
- R1: A trigger is taken on a clock edge where `trig_valid` and `trig_ready` are both high. `trig_ready` is low in exactly the cycles where `cfg_en` is high, so a register operation always goes first. A held trigger is taken on the following free cycle.
- R2: Coalescing state codes: 00 = ready, 01 = off, 10 = pending, 11 = queued. A taken trigger on an unmasked source in state 00 moves it to 10 and causes exactly one queue write. In the cycle after the accepting edge, `evq_we` and `notify_valid` are high together for one cycle.
- R3: On a message-type source, a trigger in state 10 moves it to 11 with no write. A trigger in state 11 leaves it in 11 with no write.
- R4: An EOI (`cfg_op` = 2) on a source in 11 moves it to 10 and writes one entry if the source is unmasked. An EOI on a source in 10 moves it to 00 with no write. An EOI in 00 or 01 changes nothing.
- R5: A trigger in state 01 is discarded with no write. Operation `cfg_op` = 1 writes `cfg_data[1:0]` into the state of source `cfg_sel`. After reset every source is in 01.
- R6: A trigger on a masked source writes nothing and leaves its state as it was. After reset every source is masked.
- R7: Operation `cfg_op` = 0 writes the routing entry of source `cfg_sel`. The fields are event data in `cfg_data[15:0]`, CPU from bit 16 upward, priority from bit 24 upward, and the mask in bit 31. The queue id is CPU × NUM_PRIO + priority, and the notify pulse carries the same CPU and priority.
- R8: The queue entry word carries the queue's generation toggle in bit 31 and the event data in bits 15:0. Bits 30:16 are zero.
- R9: Each write uses the queue's current index, then advances it. At index 2^size − 1 the index returns to 0 and the toggle inverts. After reset each queue has size QLOG_MAX, index 0 and toggle 1.
- R10: Operation `cfg_op` = 3 sets queue `cfg_sel` to size `cfg_data[3:0]`, limited to QLOG_MAX, with index 0 and toggle 1.
- R11: A level-type source, chosen by a bit in LSI_MAP, stays in 10 on a trigger in 10, with no write. The default map makes source 7 level-type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger request valid |
| trig_ready | output | 1 | Trigger can be taken this cycle |
| trig_src | input | 3 | Source number of the trigger |
| cfg_en | input | 1 | Register operation strobe |
| cfg_op | input | 2 | 0 route, 1 state write, 2 EOI, 3 queue setup |
| cfg_sel | input | 3 | Source or queue selected by the operation |
| cfg_data | input | 32 | Operation data |
| evq_we | output | 1 | Queue write strobe |
| evq_qid | output | 3 | Queue being written |
| evq_idx | output | 4 | Slot index within the queue |
| evq_word | output | 32 | Entry word with toggle in bit 31 |
| notify_valid | output | 1 | One-cycle notify pulse |
| notify_cpu | output | 1 | Target CPU of the notify |
| notify_prio | output | 2 | Target priority of the notify |

## Verification
An EOI that re-issues an entry and a fresh trigger both want the single event path, and they can arrive in the same cycle. The bench drives an EOI on a source in the queued state and, in that same cycle, a valid trigger on another source. It then judges three things. `trig_ready` must be low in that cycle. The next cycle must carry the EOI's write to its own queue at the expected index and toggle. The cycle after that must carry the held trigger's write to the other queue.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [1:0] {
    OP_ROUTE = 2'd0,
    OP_PQSET = 2'd1,
    OP_EOI   = 2'd2,
    OP_QCFG  = 2'd3
  } cfg_op_e;

  localparam logic [1:0] ST_READY  = 2'b00;
  localparam logic [1:0] ST_OFF    = 2'b01;
  localparam logic [1:0] ST_PEND   = 2'b10;
  localparam logic [1:0] ST_QUEUED = 2'b11;

  localparam int F_EISN_LO = 0;
  localparam int F_CPU_LO  = 16;
  localparam int F_PRIO_LO = 24;
  localparam int F_MASK    = 31;
  localparam int F_QLOG_W  = 4;

endpackage

// File: rtl/irq_src_pq.sv
module irq_src_pq
  import irq_router_pkg::*;
#(
  parameter bit IS_LSI = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig,
  input  logic       eoi,
  input  logic       st_we,
  input  logic [1:0] st_wdata,
  input  logic       masked,
  output logic [1:0] st,
  output logic       fwd
);

  logic [1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    fwd  = 1'b0;
    if (st_we) begin
      st_d = st_wdata;
    end else if (trig && !masked) begin
      case (st_q)
        ST_READY: begin
          st_d = ST_PEND;
          fwd  = 1'b1;
        end
        ST_PEND:  st_d = IS_LSI ? ST_PEND : ST_QUEUED;
        default:  st_d = st_q;
      endcase
    end else if (eoi) begin
      case (st_q)
        ST_PEND:   st_d = ST_READY;
        ST_QUEUED: begin
          st_d = ST_PEND;
          fwd  = !masked;
        end
        default:   st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign st = st_q;

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3,
  parameter int CPU_W   = 1,
  parameter int PRIO_W  = 2,
  parameter int EISN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SRC_W-1:0]  wsel,
  input  logic [31:0]       wdata,
  input  logic [SRC_W-1:0]  rsel,
  output logic [CPU_W-1:0]  r_cpu,
  output logic [PRIO_W-1:0] r_prio,
  output logic [EISN_W-1:0] r_eisn,
  output logic [NUM_SRC-1:0] mask_vec
);

  logic [CPU_W-1:0]  cpu_q  [NUM_SRC];
  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic [EISN_W-1:0] eisn_q [NUM_SRC];
  logic [NUM_SRC-1:0] mask_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cpu_q[i]  <= '0;
        prio_q[i] <= '0;
        eisn_q[i] <= '0;
        mask_q[i] <= 1'b1;
      end else if (we && wsel == SRC_W'(i)) begin
        cpu_q[i]  <= wdata[F_CPU_LO +: CPU_W];
        prio_q[i] <= wdata[F_PRIO_LO +: PRIO_W];
        eisn_q[i] <= wdata[F_EISN_LO +: EISN_W];
        mask_q[i] <= wdata[F_MASK];
      end
    end
  end

  assign r_cpu    = cpu_q[rsel];
  assign r_prio   = prio_q[rsel];
  assign r_eisn   = eisn_q[rsel];
  assign mask_vec = mask_q;

endmodule

// File: rtl/irq_evq_ctrl.sv
module irq_evq_ctrl #(
  parameter int QLOG_MAX = 4,
  parameter int LOG_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [LOG_W-1:0]    cfg_log2,
  input  logic                push,
  output logic [QLOG_MAX-1:0] idx,
  output logic                gen
);

  localparam logic [LOG_W-1:0]    QMAX_L   = LOG_W'(QLOG_MAX);
  localparam logic [QLOG_MAX-1:0] ALL_ONES = '1;

  logic [LOG_W-1:0]    log2_q;
  logic [QLOG_MAX-1:0] idx_q;
  logic                gen_q;
  logic [QLOG_MAX-1:0] last_idx;

  assign last_idx = ALL_ONES >> (QMAX_L - log2_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      log2_q <= QMAX_L;
      idx_q  <= '0;
      gen_q  <= 1'b1;
    end else if (cfg_we) begin
      log2_q <= cfg_log2;
      idx_q  <= '0;
      gen_q  <= 1'b1;
    end else if (push) begin
      if (idx_q == last_idx) begin
        idx_q <= '0;
        gen_q <= ~gen_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign idx = idx_q;
  assign gen = gen_q;

endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CPU  = 2,
  parameter int NUM_PRIO = 4,
  parameter int EISN_W   = 16,
  parameter int QLOG_MAX = 4,
  parameter logic [NUM_SRC-1:0] LSI_MAP = 8'h80,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int PRIO_W = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1,
  localparam int NUM_Q  = NUM_CPU * NUM_PRIO,
  localparam int QID_W  = CPU_W + PRIO_W,
  localparam int SEL_W  = (SRC_W > QID_W) ? SRC_W : QID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [SRC_W-1:0]  trig_src,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_op,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_data,
  output logic              evq_we,
  output logic [QID_W-1:0]  evq_qid,
  output logic [QLOG_MAX-1:0] evq_idx,
  output logic [31:0]       evq_word,
  output logic              notify_valid,
  output logic [CPU_W-1:0]  notify_cpu,
  output logic [PRIO_W-1:0] notify_prio
);

  localparam int LOG_W = $clog2(QLOG_MAX + 1);
  localparam int PAD_W = 31 - EISN_W;

  logic is_route, is_pqset, is_eoi, is_qcfg, trig_fire;
  logic [SRC_W-1:0] act_src;
  logic [SRC_W-1:0] sel_src;
  logic [QID_W-1:0] sel_q;

  assign trig_ready = !cfg_en;
  assign trig_fire  = trig_valid && trig_ready;
  assign is_route   = cfg_en && (cfg_op == OP_ROUTE);
  assign is_pqset   = cfg_en && (cfg_op == OP_PQSET);
  assign is_eoi     = cfg_en && (cfg_op == OP_EOI);
  assign is_qcfg    = cfg_en && (cfg_op == OP_QCFG);
  assign sel_src    = cfg_sel[SRC_W-1:0];
  assign sel_q      = cfg_sel[QID_W-1:0];
  assign act_src    = is_eoi ? sel_src : trig_src;

  // Routing entries
  logic [CPU_W-1:0]   r_cpu;
  logic [PRIO_W-1:0]  r_prio;
  logic [EISN_W-1:0]  r_eisn;
  logic [NUM_SRC-1:0] mask_vec;

  irq_route_table #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CPU_W(CPU_W),
    .PRIO_W(PRIO_W), .EISN_W(EISN_W)
  ) u_route (
    .clk(clk), .rst_n(rst_n),
    .we(is_route), .wsel(sel_src), .wdata(cfg_data),
    .rsel(act_src),
    .r_cpu(r_cpu), .r_prio(r_prio), .r_eisn(r_eisn),
    .mask_vec(mask_vec)
  );

  // Per-source coalescing state
  logic [2*NUM_SRC-1:0] pq_flat;
  logic [NUM_SRC-1:0]   fwd_vec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [1:0] st_i;
    irq_src_pq #(.IS_LSI(LSI_MAP[i])) u_pq (
      .clk(clk), .rst_n(rst_n),
      .trig(trig_fire && trig_src == SRC_W'(i)),
      .eoi(is_eoi && sel_src == SRC_W'(i)),
      .st_we(is_pqset && sel_src == SRC_W'(i)),
      .st_wdata(cfg_data[1:0]),
      .masked(mask_vec[i]),
      .st(st_i),
      .fwd(fwd_vec[i])
    );
    assign pq_flat[2*i +: 2] = st_i;
  end

  logic push;
  logic [QID_W-1:0] push_qid;
  assign push     = |fwd_vec;
  assign push_qid = {r_cpu, r_prio};

  // Queue size clamp for setup operation
  logic [F_QLOG_W-1:0] qlog_req;
  logic [LOG_W-1:0]    qlog_eff;
  assign qlog_req = cfg_data[F_QLOG_W-1:0];
  assign qlog_eff = (qlog_req > F_QLOG_W'(QLOG_MAX)) ? LOG_W'(QLOG_MAX)
                                                      : LOG_W'(qlog_req);

  // Per-queue index and toggle
  logic [QLOG_MAX-1:0] idx_arr [NUM_Q];
  logic [NUM_Q-1:0]    gen_vec;

  for (genvar k = 0; k < NUM_Q; k++) begin : g_q
    irq_evq_ctrl #(.QLOG_MAX(QLOG_MAX), .LOG_W(LOG_W)) u_q (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(is_qcfg && sel_q == QID_W'(k)),
      .cfg_log2(qlog_eff),
      .push(push && push_qid == QID_W'(k)),
      .idx(idx_arr[k]),
      .gen(gen_vec[k])
    );
  end

  logic [31:0] word_d;
  assign word_d = {gen_vec[push_qid], {PAD_W{1'b0}}, r_eisn};

  // Output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evq_we       <= 1'b0;
      notify_valid <= 1'b0;
      evq_qid      <= '0;
      evq_idx      <= '0;
      evq_word     <= '0;
      notify_cpu   <= '0;
      notify_prio  <= '0;
    end else begin
      evq_we       <= push;
      notify_valid <= push;
      if (push) begin
        evq_qid     <= push_qid;
        evq_idx     <= idx_arr[push_qid];
        evq_word    <= word_d;
        notify_cpu  <= r_cpu;
        notify_prio <= r_prio;
      end
    end
  end

endmodule

// File: rtl/irq_event_router_chk.sv
module irq_event_router_chk #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3,
  parameter int CPU_W   = 1,
  parameter int PRIO_W  = 2,
  parameter int QID_W   = 3,
  parameter int EISN_W  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trig_valid,
  input logic                 trig_ready,
  input logic [SRC_W-1:0]     trig_src,
  input logic                 cfg_en,
  input logic                 evq_we,
  input logic [QID_W-1:0]     evq_qid,
  input logic [31:0]          evq_word,
  input logic                 notify_valid,
  input logic [CPU_W-1:0]     notify_cpu,
  input logic [PRIO_W-1:0]    notify_prio,
  input logic [2*NUM_SRC-1:0] pq_flat,
  input logic [NUM_SRC-1:0]   mask_vec
);

  logic       fire;
  logic [1:0] src_st;
  logic       src_mask;
  assign fire     = trig_valid && trig_ready;
  assign src_st   = pq_flat[2*trig_src +: 2];
  assign src_mask = mask_vec[trig_src];

  assert_cfg_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> !trig_ready);

  assert_ready_pushes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && src_st == 2'b00 && !src_mask) |=> evq_we);

  assert_notify_pairs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evq_we |-> (notify_valid && evq_qid == {notify_cpu, notify_prio}));

  assert_pending_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && src_st[1]) |=> !evq_we);

  assert_off_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && src_st == 2'b01) |=> !evq_we);

  assert_masked_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && src_mask) |=> !evq_we);

  assert_masked_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && src_mask) |=> $stable(pq_flat));

  assert_word_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evq_we |-> (evq_word[30:EISN_W] == '0));

endmodule

bind irq_event_router irq_event_router_chk #(
  .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CPU_W(CPU_W),
  .PRIO_W(PRIO_W), .QID_W(QID_W), .EISN_W(EISN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_src(trig_src),
  .cfg_en(cfg_en),
  .evq_we(evq_we), .evq_qid(evq_qid), .evq_word(evq_word),
  .notify_valid(notify_valid), .notify_cpu(notify_cpu), .notify_prio(notify_prio),
  .pq_flat(pq_flat), .mask_vec(mask_vec)
);

// File: tb/irq_event_router_test.sv
`timescale 1ns/1ps
module irq_event_router_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic [2:0]  trig_src = '0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_op = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        evq_we;
  logic [2:0]  evq_qid;
  logic [3:0]  evq_idx;
  logic [31:0] evq_word;
  logic        notify_valid;
  logic        notify_cpu;
  logic [1:0]  notify_prio;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irq_event_router uut (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_src(trig_src),
    .cfg_en(cfg_en), .cfg_op(cfg_op), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .evq_we(evq_we), .evq_qid(evq_qid), .evq_idx(evq_idx), .evq_word(evq_word),
    .notify_valid(notify_valid), .notify_cpu(notify_cpu), .notify_prio(notify_prio)
  );

  localparam logic [1:0] OPR = 2'd0, OPS = 2'd1, OPE = 2'd2, OPQ = 2'd3;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_push(input string tag, input int qid, input int idx,
                             input logic [31:0] word);
    chk({tag, " we"},     {31'd0, evq_we}, 32'd1);
    chk({tag, " notify"}, {31'd0, notify_valid}, 32'd1);
    chk({tag, " qid"},    {29'd0, evq_qid}, qid);
    chk({tag, " idx"},    {28'd0, evq_idx}, idx);
    chk({tag, " word"},   evq_word, word);
    chk({tag, " target"}, {29'd0, notify_cpu, notify_prio}, qid);
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " no write"}, {30'd0, evq_we, notify_valid}, 32'd0);
  endtask

  task automatic do_cfg(input logic [1:0] op, input int sel, input logic [31:0] data);
    cfg_en = 1'b1; cfg_op = op; cfg_sel = 3'(sel); cfg_data = data;
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic do_trig(input int src);
    trig_valid = 1'b1; trig_src = 3'(src);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", {31'd0, trig_ready}, 32'd1);
    expect_none("R2 idle after reset");
    do_trig(0);
    expect_none("R5 R6 reset source off and masked");
  endtask

  task automatic t_basic;
    do_cfg(OPQ, 6, 32'd2);
    do_cfg(OPR, 1, 32'h0201_0123);
    do_cfg(OPS, 1, 32'd0);
    do_trig(1);
    expect_push("R2 R7 first trigger", 6, 0, 32'h8000_0123);
    @(negedge clk);
    expect_none("R2 pulse lasts one cycle");
    do_trig(1);
    expect_none("R3 trigger while pending");
    do_trig(1);
    expect_none("R3 trigger while queued");
    do_cfg(OPE, 1, 32'd0);
    expect_push("R4 EOI from queued", 6, 1, 32'h8000_0123);
    do_cfg(OPE, 1, 32'd0);
    expect_none("R4 EOI from pending");
    do_trig(1);
    expect_push("R4 ready again after EOI", 6, 2, 32'h8000_0123);
  endtask

  task automatic t_wrap;
    do_cfg(OPE, 1, 32'd0);
    do_trig(1);
    expect_push("R9 last slot", 6, 3, 32'h8000_0123);
    do_cfg(OPE, 1, 32'd0);
    do_trig(1);
    expect_push("R9 R8 wrap flips toggle", 6, 0, 32'h0000_0123);
  endtask

  task automatic t_mask;
    do_cfg(OPE, 1, 32'd0);
    do_cfg(OPR, 1, 32'h8201_0123);
    do_trig(1);
    expect_none("R6 masked trigger");
    do_cfg(OPR, 1, 32'h0201_0123);
    do_trig(1);
    expect_push("R6 state kept ready under mask", 6, 1, 32'h0000_0123);
  endtask

  task automatic t_qcfg;
    do_cfg(OPQ, 6, 32'd3);
    do_cfg(OPE, 1, 32'd0);
    do_trig(1);
    expect_push("R10 setup restarts index and toggle", 6, 0, 32'h8000_0123);
  endtask

  task automatic t_off;
    do_cfg(OPS, 1, 32'd1);
    do_trig(1);
    expect_none("R5 off discards trigger");
    do_cfg(OPE, 1, 32'd0);
    expect_none("R4 EOI in off state");
    do_cfg(OPS, 1, 32'd0);
    do_trig(1);
    expect_push("R5 state write to ready", 6, 1, 32'h8000_0123);
  endtask

  task automatic t_collision;
    do_cfg(OPR, 2, 32'h0100_0222);
    do_cfg(OPS, 2, 32'd0);
    do_cfg(OPQ, 1, 32'd3);
    do_trig(1);
    expect_none("R3 source 1 to queued");
    cfg_en = 1'b1; cfg_op = OPE; cfg_sel = 3'd1; cfg_data = '0;
    trig_valid = 1'b1; trig_src = 3'd2;
    #1;
    chk("R1 trigger held during EOI", {31'd0, trig_ready}, 32'd0);
    @(negedge clk);
    expect_push("R1 R4 EOI wins the cycle", 6, 2, 32'h8000_0123);
    cfg_en = 1'b0;
    #1;
    chk("R1 ready restored", {31'd0, trig_ready}, 32'd1);
    @(negedge clk);
    trig_valid = 1'b0;
    expect_push("R1 R7 held trigger follows", 1, 0, 32'h8000_0222);
  endtask

  task automatic t_lsi;
    do_cfg(OPR, 7, 32'h0000_7777);
    do_cfg(OPS, 7, 32'd0);
    do_cfg(OPQ, 0, 32'd0);
    do_trig(7);
    expect_push("R11 level source first", 0, 0, 32'h8000_7777);
    do_trig(7);
    expect_none("R11 level source stays pending");
    do_cfg(OPE, 7, 32'd0);
    expect_none("R11 EOI from pending");
    do_trig(7);
    expect_push("R9 single-slot queue wraps", 0, 0, 32'h0000_7777);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_mask();
    t_qcfg();
    t_off();
    t_collision();
    t_lsi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule